// File: doc/BRIEF.md
# SPI Potentiometer Command Decoder

This block is the serial front end of a four-channel digital potentiometer controller. A host selects it by pulling chip select low. It then sends an addressing byte, an instruction byte and, for some commands, one data byte, all MSB first on SI. The block keeps four 8-bit wiper positions, which drive the resistor arrays downstream. It also keeps sixteen 8-bit stored-setting registers, four for each wiper. Commands write or read either kind of register, or copy a setting between a wiper and one of its stored registers.

SCK, SI, chip select, hold and write-protect are sampled with the system clock. SCK edges are found by comparing each sample with the previous one. Read data leaves on SO. SO is high impedance whenever the block is not returning data, so SI and SO can share one wire.

Top module: `spi_pot_decoder`

## Requirements
- R1: After reset every wiper position and every stored register is 0, so_oe is 0 and SO is high impedance.
- R2: The first byte after chip select falls is accepted only if it equals {4'b0101, 2'b00, addr_pins}. Any other value makes the block ignore the rest of the transaction: no register changes and SO stays undriven.
- R3: Instruction byte layout: bits 7:4 are the opcode, bits 3:2 the stored-register index, bits 1:0 the wiper index. With opcode 4'b1010, the third byte is written to the selected wiper position (wiper_pos bits 8*w+7:8*w).
- R4: With opcode 4'b1001, the selected wiper position is shifted out MSB first on SO during the third byte. SO changes after falling SCK edges, and so_oe is high only for that byte.
- R5: With opcode 4'b1100, the third byte is written to stored register {wiper index, register index}. Opcode 4'b1011 returns that register on SO in the same way as R4.
- R6: Opcode 4'b1101 copies the selected stored register into the selected wiper position when the instruction byte completes.
- R7: Opcode 4'b1110 copies the selected wiper position into the selected stored register when the instruction byte completes.
- R8: While write-protect is low at any point in a transaction, stored-register writes (4'b1100 and 4'b1110) have no effect. Wiper writes still take effect.
- R9: Hold going low while chip select is low aborts the transaction: no register changes and SO is released.
- R10: If chip select rises before a byte is complete, the transfer is abandoned with no register change, and the next transaction decodes normally from its first bit.
- R11: Opcodes other than the six listed change no register and never drive SO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in, sampled on rising SCK |
| hold_n | input | 1 | Hold, active low; aborts a transaction |
| wp_n | input | 1 | Write-protect, active low; blocks stored-register writes |
| addr_pins | input | 2 | Strapped low bits of the slave address |
| so | output | 1 | Serial data out, high impedance when not driven |
| so_oe | output | 1 | High while SO carries read data |
| wiper_pos | output | 32 | Four wiper positions, wiper w in bits 8*w+7:8*w |

## Verification
A command's result is due at the first system clock edge that sees SCK high for the eighth bit of the byte that completes it. That byte is the data byte for writes and the instruction byte for copies. Each new SO bit is due at the first edge that sees SCK low. The bench holds every SCK level for three system clocks. It samples SO and so_oe just before it raises SCK. It reads wiper_pos only after chip select has been high for several clocks, so every result is already stable when it is checked. Stored registers are checked through read commands, and the bench keeps its own model of the expected contents.

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder #(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        si,
  input  logic        hold_n,
  input  logic        wp_n,
  input  logic [1:0]  addr_pins,
  output logic        so,
  output logic        so_oe,
  output logic [31:0] wiper_pos
);
  localparam logic [3:0] OP_RDW = 4'b1001;
  localparam logic [3:0] OP_WRW = 4'b1010;
  localparam logic [3:0] OP_RDS = 4'b1011;
  localparam logic [3:0] OP_WRS = 4'b1100;
  localparam logic [3:0] OP_LDW = 4'b1101;
  localparam logic [3:0] OP_SVW = 4'b1110;

  typedef enum logic [1:0] {S_ID, S_INS, S_DATA, S_DONE} st_t;

  st_t              st;
  logic             sck_q, rd, wp_seen;
  logic [2:0]       cnt;
  logic [6:0]       sh;
  logic [7:0]       osr;
  logic [3:0]       op;
  logic [1:0]       dsel, wsel;
  logic [3:0][7:0]  wcr;
  logic [15:0][7:0] dreg;

  wire       rise    = !cs_n && sck && !sck_q;
  wire       fall    = !cs_n && !sck && sck_q;
  wire [7:0] byte_in = {sh, si};
  wire       wp_blk  = wp_seen || !wp_n;
  wire [3:0] ins_idx = {byte_in[1:0], byte_in[3:2]};

  assign so_oe     = rd && (st == S_DATA);
  assign so        = so_oe ? osr[7] : 1'bz;
  assign wiper_pos = wcr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_ID; sck_q <= 1'b0; rd <= 1'b0; wp_seen <= 1'b0;
      cnt <= '0; sh <= '0; osr <= '0; op <= '0; dsel <= '0; wsel <= '0;
      wcr <= '0; dreg <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        st <= S_ID; cnt <= '0; rd <= 1'b0; wp_seen <= 1'b0;
      end else if (!hold_n) begin
        st <= S_DONE; rd <= 1'b0;
      end else begin
        if (!wp_n) wp_seen <= 1'b1;
        if (rise && st != S_DONE) begin
          sh  <= byte_in[6:0];
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            case (st)
              S_ID: st <= (byte_in == {DEV_TYPE, 2'b00, addr_pins}) ? S_INS : S_DONE;
              S_INS: begin
                op <= byte_in[7:4]; dsel <= byte_in[3:2]; wsel <= byte_in[1:0];
                st <= S_DONE;
                case (byte_in[7:4])
                  OP_RDW: begin osr <= wcr[byte_in[1:0]]; rd <= 1'b1; st <= S_DATA; end
                  OP_RDS: begin osr <= dreg[ins_idx]; rd <= 1'b1; st <= S_DATA; end
                  OP_WRW, OP_WRS: st <= S_DATA;
                  OP_LDW: wcr[byte_in[1:0]] <= dreg[ins_idx];
                  OP_SVW: if (!wp_blk) dreg[ins_idx] <= wcr[byte_in[1:0]];
                  default: ;
                endcase
              end
              S_DATA: begin
                st <= S_DONE; rd <= 1'b0;
                if (op == OP_WRW) wcr[wsel] <= byte_in;
                if (op == OP_WRS && !wp_blk) dreg[{wsel, dsel}] <= byte_in;
              end
              default: ;
            endcase
          end
        end
        if (fall && st == S_DATA && rd && cnt != 3'd0) osr <= {osr[6:0], 1'b0};
      end
    end
  end

  assert_oe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe);
  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> !so_oe);
  assert_wiper_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(wcr));
  assert_store_protect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(dreg));
  assert_no_z_when_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !$isunknown(so));
endmodule

// File: tb/spi_pot_decoder_tb.sv
module spi_pot_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic [1:0] addr_pins = 2'b10;
  wire so, so_oe;
  wire [31:0] wiper_pos;
  int checks = 0, errors = 0;
  logic [7:0] exp_w [4];
  logic [7:0] exp_d [16];

  always #10 clk = ~clk;

  spi_pot_decoder dut_i (.clk, .rst_n, .cs_n, .sck, .si, .hold_n, .wp_n,
                         .addr_pins, .so, .so_oe, .wiper_pos);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r, output logic oe);
    si = b; wait_clk(3);
    r = so; oe = so_oe;
    sck = 1'b1; wait_clk(3);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] oes);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i], oes[i]);
  endtask

  task automatic start();
    cs_n = 1'b0; wait_clk(2);
  endtask

  task automatic stop();
    wait_clk(3); cs_n = 1'b1; wait_clk(4);
  endtask

  function automatic logic [7:0] idb();
    return {4'b0101, 2'b00, addr_pins};
  endfunction

  task automatic cmd3(input logic [7:0] ins, input logic [7:0] d, output logic [7:0] rx, output logic [7:0] oes);
    logic [7:0] r0, o0;
    start(); xbyte(idb(), r0, o0); xbyte(ins, r0, o0); xbyte(d, rx, oes); stop();
  endtask

  task automatic cmd2(input logic [7:0] ins);
    logic [7:0] r0, o0;
    start(); xbyte(idb(), r0, o0); xbyte(ins, r0, o0); stop();
  endtask

  task automatic check_wipers(input string req);
    chk(req, wiper_pos, {exp_w[3], exp_w[2], exp_w[1], exp_w[0]});
  endtask

  task automatic read_store(input int idx, input string req);
    logic [7:0] rx, oes;
    cmd3({4'b1011, idx[1:0], idx[3:2]}, 8'h00, rx, oes);
    chk(req, {oes, rx}, {8'hFF, exp_d[idx]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx, oes, r0, o0;
    for (int i = 0; i < 4; i++) exp_w[i] = 8'h00;
    for (int i = 0; i < 16; i++) exp_d[i] = 8'h00;
    wait_clk(3); rst_n = 1'b1; wait_clk(2);
    // R1 reset state
    check_wipers("R1 wipers");
    chk("R1 oe", so_oe, 1'b0);
    chk("R1 so z", so === 1'bz, 1'b1);
    read_store(5, "R1 store");

    // R3 write every wiper
    for (int w = 0; w < 4; w++) begin
      exp_w[w] = 8'(w * 37 + 5);
      cmd3({4'b1010, 2'b00, 2'(w)}, exp_w[w], rx, oes);
      check_wipers("R3 write wiper");
    end
    // R4 read every wiper, so_oe high for data byte, released after
    for (int w = 0; w < 4; w++) begin
      cmd3({4'b1001, 2'b11, 2'(w)}, 8'h00, rx, oes);
      chk("R4 read wiper", {oes, rx}, {8'hFF, exp_w[w]});
      chk("R4 released", {so_oe, so === 1'bz}, 2'b01);
    end
    // R5 write and read every stored register
    for (int i = 0; i < 16; i++) begin
      exp_d[i] = 8'(i * 13 + 1);
      cmd3({4'b1100, 2'(i), 2'(i >> 2)}, exp_d[i], rx, oes);
    end
    for (int i = 0; i < 16; i++) read_store(i, "R5 store readback");
    check_wipers("R5 wipers untouched");

    // R6 load wiper from stored register, sweeping index
    for (int w = 0; w < 4; w++) begin
      cmd2({4'b1101, 2'(3 - w), 2'(w)});
      exp_w[w] = exp_d[w * 4 + (3 - w)];
      check_wipers("R6 load");
    end
    // R7 save wiper into stored register
    for (int w = 0; w < 4; w++) begin
      exp_w[w] = 8'hC0 + 8'(w);
      cmd3({4'b1010, 2'b00, 2'(w)}, exp_w[w], rx, oes);
      cmd2({4'b1110, 2'(w), 2'(w)});
      exp_d[w * 4 + w] = exp_w[w];
      read_store(w * 4 + w, "R7 save");
    end

    // R2 sweep all low nibbles and a bad type
    for (int n = 0; n < 16; n++) begin
      start(); xbyte({4'b0101, 4'(n)}, r0, o0); xbyte(8'b1010_0000, r0, o0);
      xbyte(8'hA0 + 8'(n), r0, o0); stop();
      if (4'(n) == {2'b00, addr_pins}) exp_w[0] = 8'hA0 + 8'(n);
      check_wipers("R2 address sweep");
    end
    start(); xbyte({4'b0110, 2'b00, addr_pins}, r0, o0); xbyte(8'b1001_0000, r0, o0);
    xbyte(8'h00, rx, oes); stop();
    chk("R2 bad type no drive", oes, 8'h00);
    check_wipers("R2 bad type");

    // R11 undefined opcodes
    for (int o = 0; o < 16; o++) begin
      if (o >= 9 && o <= 14) continue;
      cmd3({4'(o), 2'b01, 2'b01}, 8'h5A, rx, oes);
      chk("R11 no drive", oes, 8'h00);
      check_wipers("R11 wipers");
    end
    read_store(5, "R11 store");

    // R8 write-protect
    wp_n = 1'b0;
    cmd3(8'b1100_0110, 8'h77, rx, oes);
    cmd2(8'b1110_0001);
    exp_w[2] = 8'h3C;
    cmd3(8'b1010_0010, 8'h3C, rx, oes);
    wp_n = 1'b1;
    read_store(9, "R8 store write blocked");
    read_store(1 * 4 + 0, "R8 save blocked");
    check_wipers("R8 wiper write allowed");
    start(); xbyte(idb(), r0, o0); wp_n = 1'b0; xbyte(8'b1100_0111, r0, o0);
    wp_n = 1'b1; xbyte(8'h66, r0, o0); stop();
    read_store(13, "R8 pulse blocks");

    // R9 hold abort
    start(); xbyte(idb(), r0, o0); hold_n = 1'b0; wait_clk(4); hold_n = 1'b1;
    xbyte(8'b1010_0011, r0, o0); xbyte(8'h11, r0, o0); stop();
    check_wipers("R9 hold write");
    start(); xbyte(idb(), r0, o0); xbyte(8'b1001_0001, r0, o0);
    xbit(1'b0, rx[7], oes[7]); hold_n = 1'b0; wait_clk(3);
    chk("R9 so released", {so_oe, so === 1'bz}, 2'b01);
    hold_n = 1'b1; stop();

    // R10 chip select rises mid-byte
    start(); xbyte(idb(), r0, o0); xbyte(8'b1010_0001, r0, o0);
    for (int i = 0; i < 5; i++) xbit(1'b1, rx[0], oes[0]);
    stop();
    check_wipers("R10 partial data");
    start(); for (int i = 0; i < 3; i++) xbit(1'b0, rx[0], oes[0]); stop();
    exp_w[1] = 8'h99;
    cmd3(8'b1010_0001, 8'h99, rx, oes);
    check_wipers("R10 recover");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule